// File: doc/BRIEF.md
# SWD Host Transaction Engine

This block is the host end of a two-wire serial debug link. It makes the serial clock from the system clock and drives, releases and samples the shared bidirectional data line. The line's pad is presented as three signals: a drive value, an output enable and a sampled input. A controller sets the access type (debug-port or access-port register), the direction, a 2-bit register address and the write data, then pulses a command. The engine then runs one complete transaction on the wire. When the transaction ends it reports the 3-bit acknowledge, the read data and a flag that marks bad read parity.

The engine is a single state machine. Its states are READY, REQ (eight request bits), TRN_IN (turnaround after the park bit), ACK (three acknowledge bits), TRN_W (turnaround before write data), WDATA (32 bits plus parity), RDATA (32 bits plus parity), TRN_BACK (turnaround before the host drives again) and IDLE (eight low clocks).

The transitions are:
- READY goes to REQ when a command is accepted.
- REQ goes to TRN_IN after the park bit.
- TRN_IN goes to ACK after the turnaround.
- ACK goes to TRN_W for a write or to RDATA for a read, if the acknowledge is OK or overrun detection is on. Otherwise it goes to TRN_BACK.
- TRN_W goes to WDATA.
- WDATA goes to IDLE.
- RDATA goes to TRN_BACK.
- TRN_BACK goes to IDLE.
- IDLE goes to READY after the eighth idle clock.

Data changes on the falling edge of the serial clock and is sampled on the rising edge.

Top module: `swd_host_engine`

## Requirements
- R1: The request is 8 bits, driven in this order: 1, access-type bit (0 for a debug-port register, 1 for an access-port register), direction bit (0 for a write, 1 for a read), address bit 0, address bit 1, even parity over those four bits, 0, 1.
- R2: After the request the line is released (enable low) for trn_cfg+1 serial clocks. The 3-bit acknowledge is then sampled, least significant bit first, with the line still released. The acknowledge is reported on `ack`. OK is 001, WAIT is 010 and FAULT is 100.
- R3: On a write that goes on to its data phase, a second turnaround of trn_cfg+1 released clocks follows the acknowledge. The host then drives 32 data bits, least significant bit first, and then their even parity. The line stays driven afterwards with no turnaround.
- R4: On a read that goes on to its data phase, 32 data bits and a parity bit are sampled directly after the acknowledge. Then trn_cfg+1 released clocks pass before the host drives again. The data is reported on `rdata`.
- R5: `rd_perr` is set when the received parity bit differs from the even parity of the 32 read data bits alone. It is cleared when the next command is accepted.
- R6: An acknowledge other than OK with `ovr_detect` low ends the transaction after one turnaround of trn_cfg+1 clocks. No data is driven or sampled, and `rdata` keeps its previous value.
- R7: With `ovr_detect` high, the data phase runs whatever the acknowledge is.
- R8: Each half period of the serial clock lasts clk_div+1 system clocks. The drive value and the enable change only when the serial clock falls.
- R9: Every transaction ends with exactly 8 serial clocks with the line driven low. After that the serial clock stops high and `cmd_ready` returns. `done` is a one-cycle pulse at the rising edge that closes the last data-phase or turnaround slot.
- R10: After reset the serial clock is high, the line is driven low, `cmd_ready` is high and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | DIV_W | Serial half-period length minus one, in system clocks |
| trn_cfg | input | TRN_W | Turnaround length minus one, in serial clocks |
| ovr_detect | input | 1 | Run the data phase even without an OK acknowledge |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle; a command is taken when both are high |
| cmd_apndp | input | 1 | 0 selects a debug-port register, 1 an access-port register |
| cmd_rnw | input | 1 | 0 for a write, 1 for a read |
| cmd_addr | input | 2 | Register address bits 3:2 |
| cmd_wdata | input | DATA_W | Write data |
| done | output | 1 | One-cycle end-of-transaction pulse |
| ack | output | 3 | Acknowledge received |
| rdata | output | DATA_W | Read data received |
| rd_perr | output | 1 | Read parity mismatch |
| swclk | output | 1 | Serial clock |
| swdio_o | output | 1 | Line drive value |
| swdio_oe | output | 1 | Line drive enable |
| swdio_i | input | 1 | Sampled line value |

## Verification
The bench acts as the target. It decodes each request from the wire and answers with a chosen acknowledge and chosen read data. Directed cases cover four things:
- An OK read with corrupted parity, which isolates the parity flag.
- A WAIT write and a no-response acknowledge, which show the data phase being skipped.
- A FAULT read with overrun detection on, which separates the acknowledge from the data-phase decision.
- The largest turnaround together with the fastest clock.

Random transactions then mix direction, address, data, acknowledge, turnaround length and divider. Each one checks the request bits, how long the line is released, the data on the wire, the idle tail and the stopped clock. Together they tell apart wrongly placed turnarounds, off-by-one slot counts and parity taken over the wrong bits.

// File: rtl/swd_host_pkg.sv
package swd_host_pkg;

    typedef enum logic [3:0] {
        S_READY,
        S_REQ,
        S_TRN_IN,
        S_ACK,
        S_TRN_W,
        S_WDATA,
        S_RDATA,
        S_TRN_BACK,
        S_IDLE
    } swd_state_t;

    localparam logic [2:0] ACK_OK    = 3'b001;
    localparam logic [2:0] ACK_WAIT  = 3'b010;
    localparam logic [2:0] ACK_FAULT = 3'b100;

    localparam int REQ_BITS = 8;
    localparam int ACK_BITS = 3;

endpackage

// File: rtl/swd_tick_gen.sv
module swd_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || cnt == div) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = en && (cnt == div);

endmodule

// File: rtl/swd_req_builder.sv
module swd_req_builder
    import swd_host_pkg::*;
(
    input  logic                apndp,
    input  logic                rnw,
    input  logic [1:0]          addr,
    output logic [REQ_BITS-1:0] pkt
);

    logic par;

    assign par = ^{apndp, rnw, addr};

    // wire order: bit 0 goes out first
    assign pkt = {1'b1, 1'b0, par, addr[1], addr[0], rnw, apndp, 1'b1};

endmodule

// File: rtl/swd_host_engine.sv
module swd_host_engine
    import swd_host_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int DATA_W     = 32,
    parameter int TRN_W      = 2,
    parameter int IDLE_SLOTS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [TRN_W-1:0]  trn_cfg,
    input  logic              ovr_detect,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_apndp,
    input  logic              cmd_rnw,
    input  logic [1:0]        cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              done,
    output logic [2:0]        ack,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_perr,
    output logic              swclk,
    output logic              swdio_o,
    output logic              swdio_oe,
    input  logic              swdio_i
);

    localparam int CNT_W = $clog2(DATA_W + 1 + IDLE_SLOTS + (1 << TRN_W) + REQ_BITS);
    localparam int IDX_W = $clog2(DATA_W);

    swd_state_t state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    logic                tick, rise, fall, running, accept;
    logic [REQ_BITS-1:0] req_pkt, pkt_q;
    logic                rnw_q, ovr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [TRN_W-1:0]    trn_q;
    logic                trn_end, data_end, data_go;
    logic [2:0]          ack_full;

    assign running   = (state != S_READY);
    assign cmd_ready = (state == S_READY);
    assign accept    = cmd_valid && cmd_ready;
    assign rise      = tick && !swclk;
    assign fall      = tick && swclk;
    assign trn_end   = (cnt == CNT_W'(trn_q));
    assign data_end  = (cnt == CNT_W'(DATA_W));
    assign ack_full  = {swdio_i, ack[1:0]};
    assign data_go   = (ack_full == ACK_OK) || ovr_q;

    swd_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (running),
        .div   (clk_div),
        .tick  (tick)
    );

    swd_req_builder u_req (
        .apndp (cmd_apndp),
        .rnw   (cmd_rnw),
        .addr  (cmd_addr),
        .pkt   (req_pkt)
    );

    // next state: slots advance on the serial rising edge
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        if (accept) begin
            state_nx = S_REQ;
            cnt_nx   = '0;
        end else if (rise) begin
            cnt_nx = cnt + 1'b1;
            unique case (state)
                S_REQ: begin
                    if (cnt == CNT_W'(REQ_BITS - 1)) begin
                        state_nx = S_TRN_IN;
                        cnt_nx   = '0;
                    end
                end
                S_TRN_IN: begin
                    if (trn_end) begin
                        state_nx = S_ACK;
                        cnt_nx   = '0;
                    end
                end
                S_ACK: begin
                    if (cnt == CNT_W'(ACK_BITS - 1)) begin
                        cnt_nx = '0;
                        if (!data_go)   state_nx = S_TRN_BACK;
                        else if (rnw_q) state_nx = S_RDATA;
                        else            state_nx = S_TRN_W;
                    end
                end
                S_TRN_W: begin
                    if (trn_end) begin
                        state_nx = S_WDATA;
                        cnt_nx   = '0;
                    end
                end
                S_WDATA: begin
                    if (data_end) begin
                        state_nx = S_IDLE;
                        cnt_nx   = '0;
                    end
                end
                S_RDATA: begin
                    if (data_end) begin
                        state_nx = S_TRN_BACK;
                        cnt_nx   = '0;
                    end
                end
                S_TRN_BACK: begin
                    if (trn_end) begin
                        state_nx = S_IDLE;
                        cnt_nx   = '0;
                    end
                end
                S_IDLE: begin
                    if (cnt == CNT_W'(IDLE_SLOTS - 1)) begin
                        state_nx = S_READY;
                        cnt_nx   = '0;
                    end
                end
                S_READY: cnt_nx = cnt;
                default: begin
                    state_nx = S_READY;
                    cnt_nx   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_READY;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // outputs, command capture and sampling
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            swclk    <= 1'b1;
            swdio_o  <= 1'b0;
            swdio_oe <= 1'b1;
            done     <= 1'b0;
            ack      <= '0;
            rdata    <= '0;
            rd_perr  <= 1'b0;
            pkt_q    <= '0;
            rnw_q    <= 1'b0;
            ovr_q    <= 1'b0;
            wdata_q  <= '0;
            trn_q    <= '0;
        end else begin
            done <= rise && (state_nx == S_IDLE) && (state != S_IDLE);
            if (accept) begin
                pkt_q   <= req_pkt;
                rnw_q   <= cmd_rnw;
                ovr_q   <= ovr_detect;
                wdata_q <= cmd_wdata;
                trn_q   <= trn_cfg;
                rd_perr <= 1'b0;
            end
            if (tick) begin
                swclk <= ~swclk;
            end
            if (fall) begin
                unique case (state)
                    S_REQ: begin
                        swdio_o  <= pkt_q[cnt[2:0]];
                        swdio_oe <= 1'b1;
                    end
                    S_WDATA: begin
                        swdio_o  <= data_end ? ^wdata_q : wdata_q[cnt[IDX_W-1:0]];
                        swdio_oe <= 1'b1;
                    end
                    S_IDLE, S_READY: begin
                        swdio_o  <= 1'b0;
                        swdio_oe <= 1'b1;
                    end
                    default: begin
                        swdio_o  <= 1'b0;
                        swdio_oe <= 1'b0;
                    end
                endcase
            end
            if (rise) begin
                if (state == S_ACK) begin
                    ack[cnt[1:0]] <= swdio_i;
                end
                if (state == S_RDATA) begin
                    if (data_end) begin
                        rd_perr <= swdio_i ^ (^rdata);
                    end else begin
                        rdata[cnt[IDX_W-1:0]] <= swdio_i;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/swd_host_chk.sv
module swd_host_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic cmd_ready,
    input logic done,
    input logic rd_perr,
    input logic swclk,
    input logic swdio_o,
    input logic swdio_oe
);

    // R10
    ready_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> swclk);

    // R8
    drive_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(swdio_o) |-> $fell(swclk));

    // R8
    enable_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(swdio_oe) |-> $fell(swclk));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $rose(swclk));

    // R5
    perr_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !rd_perr);

    // R2
    released_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !swdio_oe |-> !cmd_ready);

endmodule

bind swd_host_engine swd_host_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .done      (done),
    .rd_perr   (rd_perr),
    .swclk     (swclk),
    .swdio_o   (swdio_o),
    .swdio_oe  (swdio_oe)
);

// File: tb/sim_swd_host_engine.sv
module sim_swd_host_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  clk_div = 8'd1;
    logic [1:0]  trn_cfg = 2'd0;
    logic        ovr_detect = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_apndp = 1'b0;
    logic        cmd_rnw = 1'b0;
    logic [1:0]  cmd_addr = 2'd0;
    logic [31:0] cmd_wdata = '0;
    logic        done;
    logic [2:0]  ack;
    logic [31:0] rdata;
    logic        rd_perr;
    logic        swclk, swdio_o, swdio_oe;
    logic        swdio_i = 1'b0;

    always #10 clk = ~clk;

    swd_host_engine u0 (
        .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .trn_cfg(trn_cfg),
        .ovr_detect(ovr_detect), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_apndp(cmd_apndp), .cmd_rnw(cmd_rnw), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .done(done), .ack(ack), .rdata(rdata),
        .rd_perr(rd_perr), .swclk(swclk), .swdio_o(swdio_o),
        .swdio_oe(swdio_oe), .swdio_i(swdio_i)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int done_cnt = 0;
    int falls = 0;
    logic [2:0]  ack_cap;
    logic [31:0] rdata_cap;
    logic        perr_cap;
    logic [31:0] last_rd = '0;

    always @(posedge clk) begin
        if (done) begin
            done_cnt  <= done_cnt + 1;
            ack_cap   <= ack;
            rdata_cap <= rdata;
            perr_cap  <= rd_perr;
        end
    end

    always @(negedge swclk) falls <= falls + 1;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_req(input logic apndp, input logic rnw,
                                           input logic [1:0] addr);
        return {1'b1, 1'b0, apndp ^ rnw ^ addr[0] ^ addr[1], addr[1], addr[0], rnw, apndp, 1'b1};
    endfunction

    task automatic run_txn(input logic apndp, input logic rnw, input logic [1:0] addr,
                           input logic [31:0] wd, input logic [2:0] ackv,
                           input logic [31:0] rd, input logic bad_par,
                           input logic [1:0] trn, input logic [7:0] dv, input logic ovr);
        logic [7:0]  got;
        logic [31:0] gw;
        logic        gp;
        logic        bad;
        logic        go;
        realtime     t0, t1;
        int          d0, f0;
        string       tag;
        clk_div = dv;
        trn_cfg = trn;
        ovr_detect = ovr;
        d0 = done_cnt;
        go = (ackv == 3'b001) || ovr;
        tag = (go && ackv != 3'b001) ? "R7" : (go ? (rnw ? "R4" : "R3") : "R6");
        @(negedge clk);
        check("R10", "ready before command", {31'd0, cmd_ready}, 32'd1);
        cmd_apndp = apndp; cmd_rnw = rnw; cmd_addr = addr; cmd_wdata = wd;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        // request phase
        bad = 1'b0;
        t0 = 0; t1 = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge swclk);
            if (i == 0) t0 = $realtime;
            if (i == 1) t1 = $realtime;
            #2;
            got[i] = swdio_o;
            if (!swdio_oe) bad = 1'b1;
        end
        check("R1", "request bits", {24'd0, got}, {24'd0, exp_req(apndp, rnw, addr)});
        check("R1", "request driven", {31'd0, bad}, 32'd0);
        check("R8", "serial period ns", int'(t1 - t0), 40 * (int'(dv) + 1));
        // turnaround and acknowledge
        bad = 1'b0;
        repeat (int'(trn) + 1) begin
            @(negedge swclk); #2;
            if (swdio_oe) bad = 1'b1;
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge swclk); #1;
            swdio_i = ackv[k];
            #1;
            if (swdio_oe) bad = 1'b1;
        end
        check("R2", "line released for turnaround and ack", {31'd0, bad}, 32'd0);
        bad = 1'b0;
        if (go && !rnw) begin
            repeat (int'(trn) + 1) begin
                @(negedge swclk); #2;
                if (swdio_oe) bad = 1'b1;
            end
            for (int j = 0; j < 33; j++) begin
                @(negedge swclk); #2;
                if (!swdio_oe) bad = 1'b1;
                if (j < 32) gw[j] = swdio_o; else gp = swdio_o;
            end
            check(tag, "write data on wire", gw, wd);
            check(tag, "write parity", {31'd0, gp}, {31'd0, ^wd});
            check(tag, "write turnaround and drive", {31'd0, bad}, 32'd0);
        end else if (go && rnw) begin
            for (int j = 0; j < 33; j++) begin
                @(negedge swclk); #1;
                swdio_i = (j < 32) ? rd[j] : ((^rd) ^ bad_par);
                #1;
                if (swdio_oe) bad = 1'b1;
            end
            repeat (int'(trn) + 1) begin
                @(negedge swclk); #2;
                swdio_i = 1'b0;
                if (swdio_oe) bad = 1'b1;
            end
            check(tag, "read phase released", {31'd0, bad}, 32'd0);
        end else begin
            repeat (int'(trn) + 1) begin
                @(negedge swclk); #2;
                if (swdio_oe) bad = 1'b1;
            end
            check("R6", "single turnaround after non-OK", {31'd0, bad}, 32'd0);
        end
        swdio_i = 1'b0;
        // idle tail
        bad = 1'b0;
        repeat (8) begin
            @(negedge swclk); #2;
            if (!swdio_oe || swdio_o) bad = 1'b1;
        end
        check("R9", "idle slots driven low", {31'd0, bad}, 32'd0);
        wait (cmd_ready == 1'b1);
        @(negedge clk);
        f0 = falls;
        repeat (10 * (int'(dv) + 2)) @(negedge clk);
        check("R9", "clock stopped after 8 idle", falls - f0, 0);
        check("R9", "clock parks high", {31'd0, swclk}, 32'd1);
        check("R9", "one done pulse", done_cnt - d0, 1);
        check("R2", "ack reported", {29'd0, ack_cap}, {29'd0, ackv});
        if (go && rnw) last_rd = rd;
        check(tag, "rdata reported", rdata_cap, last_rd);
        check("R5", "read parity flag", {31'd0, perr_cap}, {31'd0, go && rnw && bad_par});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R10", "reset swclk", {31'd0, swclk}, 32'd1);
        check("R10", "reset line enable", {31'd0, swdio_oe}, 32'd1);
        check("R10", "reset line value", {31'd0, swdio_o}, 32'd0);
        check("R10", "reset done", {31'd0, done}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R10", "ready after reset", {31'd0, cmd_ready}, 32'd1);
        // directed corner cases
        run_txn(1'b0, 1'b1, 2'b00, 32'h0, 3'b001, 32'h1BA0_1477, 1'b0, 2'd0, 8'd1, 1'b0);
        run_txn(1'b1, 1'b1, 2'b11, 32'h0, 3'b001, 32'hA5A5_0F0F, 1'b1, 2'd1, 8'd2, 1'b0);
        run_txn(1'b1, 1'b0, 2'b10, 32'hDEAD_BEEF, 3'b001, 32'h0, 1'b0, 2'd3, 8'd0, 1'b0);
        run_txn(1'b0, 1'b0, 2'b01, 32'h1234_5678, 3'b010, 32'h0, 1'b0, 2'd0, 8'd1, 1'b0);
        run_txn(1'b1, 1'b1, 2'b01, 32'h0, 3'b111, 32'hFFFF_0000, 1'b0, 2'd2, 8'd1, 1'b0);
        run_txn(1'b1, 1'b1, 2'b00, 32'h0, 3'b100, 32'h8000_0001, 1'b1, 2'd1, 8'd0, 1'b1);
        run_txn(1'b0, 1'b0, 2'b11, 32'hFFFF_FFFF, 3'b100, 32'h0, 1'b0, 2'd0, 8'd3, 1'b1);
        // random mix
        for (int n = 0; n < 36; n++) begin
            logic [2:0] a;
            int r;
            r = $urandom % 8;
            a = (r < 5) ? 3'b001 : (r == 5) ? 3'b010 : (r == 6) ? 3'b100 : 3'b111;
            run_txn(1'($urandom), 1'($urandom), 2'($urandom), $urandom, a, $urandom,
                    1'(($urandom % 4) == 0), 2'($urandom), 8'($urandom % 4),
                    1'(($urandom % 5) == 0));
        end
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule